// File: doc/BRIEF.md
# Triple-Port Integer Register Bank

This block is the general-purpose register storage for a small integer datapath. It holds thirty-two words of 32 bits each. Two operand ports read at the same time, and one result port writes. Each read is purely combinational from its address, so operands are ready within the same cycle. A write is captured on the rising clock edge, but only while the write strobe is high.

Index zero is a constant. It always returns zero on both read ports, and any write aimed at it is discarded. When a read port addresses the same nonzero entry that is being written in the same cycle, that port returns the incoming write data instead of the stored value. A following pipeline stage therefore sees the result without waiting a cycle. A synchronous reset clears every entry.

Top module: `regbank_top`

## Requirements
- R1: After a synchronous reset (rstN low at a rising edge), every entry reads 0 on both read ports.
- R2: With wrEn high at a rising edge and wrAddr nonzero, the entry at wrAddr holds wrData afterwards.
- R3: With wrEn low at a rising edge, no entry changes value.
- R4: Reading address 0 returns 0 on either port at all times, including after a write with wrAddr = 0 and while such a write is presented.
- R5: When wrEn is high, wrAddr is nonzero and a read address equals wrAddr, that read port returns wrData combinationally in the same cycle.
- R6: The two read ports are independent: each returns the value of its own address, including when both addresses are the same.
- R7: A write to one entry leaves every other entry unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous active-low reset |
| rdAddrA | input | 5 | Read address, port A |
| rdAddrB | input | 5 | Read address, port B |
| wrAddr | input | 5 | Write address |
| wrData | input | 32 | Write data |
| wrEn | input | 1 | Write strobe |
| rdDataA | output | 32 | Read data, port A |
| rdDataB | output | 32 | Read data, port B |

## Verification
The hardest case to reach is a same-cycle bypass in which a write to entry zero is active while both read ports also point at zero. The bench produces it by holding wrEn high with wrAddr = 0 and wrData set to a non-zero pattern, then sampling both ports before the edge. It then confirms that the write is both hidden from the reads and dropped from storage. Bypass to a nonzero entry is covered as well, with one port hitting the write address and the other missing it. A behavioural array model checks both read ports on every cycle of a long pseudo-random run that deliberately aliases addresses.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int DataW  = 32;
  localparam int Depth  = 32;
  localparam int AddrW  = $clog2(Depth);

  typedef struct packed {
    logic             wrStrobe;
    logic [AddrW-1:0] wrIdx;
    logic             bypassA;
    logic             bypassB;
    logic             zeroA;
    logic             zeroB;
  } regbank_ctrl_t;
endpackage

// File: rtl/regbank_ctrl.sv
module regbank_ctrl
  import regbank_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [AddrW-1:0] rdAddrA,
  input  logic [AddrW-1:0] rdAddrB,
  input  logic [AddrW-1:0] wrAddr,
  input  logic             wrEn,
  output regbank_ctrl_t    ctrl
);
  logic wrLive;

  always_comb begin
    wrLive        = wrEn && (wrAddr != '0);
    ctrl.wrStrobe = wrLive;
    ctrl.wrIdx    = wrAddr;
    ctrl.zeroA    = (rdAddrA == '0);
    ctrl.zeroB    = (rdAddrB == '0);
    ctrl.bypassA  = wrLive && (rdAddrA == wrAddr);
    ctrl.bypassB  = wrLive && (rdAddrB == wrAddr);
  end

  // R4
  no_zero_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrAddr == '0) |-> !ctrl.wrStrobe);

  // R5
  no_zero_bypass_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.zeroA |-> !ctrl.bypassA);
endmodule

// File: rtl/regbank_dp.sv
module regbank_dp
  import regbank_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  regbank_ctrl_t    ctrl,
  input  logic [AddrW-1:0] rdAddrA,
  input  logic [AddrW-1:0] rdAddrB,
  input  logic [DataW-1:0] wrData,
  output logic [DataW-1:0] rdDataA,
  output logic [DataW-1:0] rdDataB
);
  logic [DataW-1:0] store [Depth];

  assign store[0] = '0;

  for (genvar i = 1; i < Depth; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN)
        store[i] <= '0;
      else if (ctrl.wrStrobe && (ctrl.wrIdx == AddrW'(i)))
        store[i] <= wrData;
    end
  end

  always_comb begin
    if (ctrl.zeroA)        rdDataA = '0;
    else if (ctrl.bypassA) rdDataA = wrData;
    else                   rdDataA = store[rdAddrA];
    if (ctrl.zeroB)        rdDataB = '0;
    else if (ctrl.bypassB) rdDataB = wrData;
    else                   rdDataB = store[rdAddrB];
  end

  // R2
  write_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.wrStrobe |=> (store[$past(ctrl.wrIdx)] == $past(wrData)));

  // R4
  zero_read_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddrA == '0) |-> (rdDataA == '0));

  // R4
  zero_read_b_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddrB == '0) |-> (rdDataB == '0));

  // R6
  same_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddrA == rdAddrB) |-> (rdDataA == rdDataB));
endmodule

// File: rtl/regbank_top.sv
module regbank_top
  import regbank_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [4:0]  rdAddrA,
  input  logic [4:0]  rdAddrB,
  input  logic [4:0]  wrAddr,
  input  logic [31:0] wrData,
  input  logic        wrEn,
  output logic [31:0] rdDataA,
  output logic [31:0] rdDataB
);
  regbank_ctrl_t ctrl;

  regbank_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rdAddrA(rdAddrA), .rdAddrB(rdAddrB),
    .wrAddr(wrAddr), .wrEn(wrEn), .ctrl(ctrl)
  );

  regbank_dp u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .rdAddrA(rdAddrA), .rdAddrB(rdAddrB),
    .wrData(wrData), .rdDataA(rdDataA), .rdDataB(rdDataB)
  );

  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && (rdAddrA == $past(rdAddrA)) && !$past(wrEn) && $past(rstN))
      |-> $stable(rdDataA));
endmodule

// File: tb/regbank_top_test.sv
module regbank_top_test;
  logic        clk = 0;
  logic        rstN = 0;
  logic [4:0]  rdAddrA = 0, rdAddrB = 0, wrAddr = 0;
  logic [31:0] wrData = 0;
  logic        wrEn = 0;
  logic [31:0] rdDataA, rdDataB;

  int testsRun = 0;
  int testsFailed = 0;
  logic [31:0] model [32];
  logic        done = 0;

  always #4 clk = ~clk;

  regbank_top uut (.*);

  function automatic logic [31:0] expRead(input logic [4:0] a);
    if (a == 0) return 32'h0;
    if (wrEn && wrAddr != 0 && wrAddr == a) return wrData;
    return model[a];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // model update on each edge
  always @(posedge clk) begin
    if (!rstN) for (int i = 0; i < 32; i++) model[i] <= 0;
    else if (wrEn && wrAddr != 0) model[wrAddr] <= wrData;
  end

  task automatic tick;
    @(posedge clk); #2;
  endtask

  task automatic sampleBoth(input string req);
    #1;
    check(req, rdDataA, expRead(rdAddrA));
    check(req, rdDataB, expRead(rdAddrB));
  endtask

  initial begin
    #150000;
    if (!done) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = 32'hDEAD_0000 | i;
    rstN = 0; tick; tick; rstN = 1;
    // R1 reset state
    for (int i = 0; i < 32; i++) begin
      rdAddrA = 5'(i); rdAddrB = 5'(31 - i); #1;
      check("R1", rdDataA, 32'h0);
      check("R1", rdDataB, 32'h0);
    end
    // R2 write every entry, R7 via full readback
    for (int i = 1; i < 32; i++) begin
      wrEn = 1; wrAddr = 5'(i); wrData = 32'hA500_0000 + 32'(i * 257);
      tick;
    end
    wrEn = 0;
    for (int i = 0; i < 32; i++) begin
      rdAddrA = 5'(i); rdAddrB = 5'(i); #1;
      check("R2", rdDataA, i == 0 ? 32'h0 : 32'hA500_0000 + 32'(i * 257));
      check("R6", rdDataB, rdDataA);
    end
    // R3 write data presented with wrEn low
    wrAddr = 7; wrData = 32'h1234_5678; wrEn = 0; tick;
    rdAddrA = 7; #1; check("R3", rdDataA, 32'hA500_0000 + 32'(7 * 257));
    // R4 write to zero, presented and after
    wrEn = 1; wrAddr = 0; wrData = 32'hFFFF_FFFF; rdAddrA = 0; rdAddrB = 0; #1;
    check("R4", rdDataA, 32'h0); check("R4", rdDataB, 32'h0);
    tick; wrEn = 0; #1;
    check("R4", rdDataA, 32'h0); check("R4", rdDataB, 32'h0);
    // R5 bypass on A only, B misses
    wrEn = 1; wrAddr = 9; wrData = 32'hCAFE_F00D; rdAddrA = 9; rdAddrB = 10; #1;
    check("R5", rdDataA, 32'hCAFE_F00D);
    check("R5", rdDataB, 32'hA500_0000 + 32'(10 * 257));
    tick; wrEn = 0; #1;
    // R7 neighbours of 9 untouched
    rdAddrA = 8; rdAddrB = 10; #1;
    check("R7", rdDataA, 32'hA500_0000 + 32'(8 * 257));
    check("R7", rdDataB, 32'hA500_0000 + 32'(10 * 257));
    // random run with reference comparison each cycle (R2 R3 R5 R6)
    for (int n = 0; n < 3000; n++) begin
      wrEn = $urandom_range(0, 1);
      wrAddr = 5'($urandom_range(0, 7));
      wrData = $urandom;
      rdAddrA = 5'($urandom_range(0, 7));
      rdAddrB = ($urandom_range(0, 3) == 0) ? rdAddrA : 5'($urandom_range(0, 7));
      sampleBoth("R5/R6");
      tick;
    end
    wrEn = 0;
    // R1 mid-run reset
    rstN = 0; tick; rstN = 1;
    rdAddrA = 9; rdAddrB = 31; #1;
    check("R1", rdDataA, 32'h0); check("R1", rdDataB, 32'h0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule